// File: doc/BRIEF.md
# Fourth-Order Decimating Filter with Two Selectable Output Rates

This block turns a one-bit delta-sigma modulator stream into signed 18-bit conversion results. The filter is a fourth-order cascaded integrator-comb: four integrators run at the modulator rate, and four comb stages run once per conversion. The overall response is a sinc to the fourth power, so each notch carries four coincident zeros. With a 76.8 kHz modulator rate, the slow setting gives 10 results per second, with notches at every multiple of 10 Hz. That places notches on both 50 Hz and 60 Hz mains at once. The fast setting gives 80 results per second.

The `rateSel` pin picks the decimation ratio at run time: 7680 when low, 960 when high. Any change of the pin wipes the filter history. Each result arrives with a one-cycle strobe. It is scaled to the 18-bit two's complement range and clipped at the asymmetric limits. A `settled` flag rises once the history holds only data gathered since the last clear. Software can use it to discard the partly settled readings that follow a reset or a rate change.

Top module: `sinc4_rate_decimator`

## Requirements
- R1: During and right after reset, `resultValid` and `settled` are 0 and `resultCode` is 0.
- R2: `resultValid` is high for exactly one cycle per conversion. `resultCode` changes only with it. With `sampleEn` held high, consecutive strobes are 960 cycles apart when `rateSel`=1 and 7680 cycles apart when `rateSel`=0.
- R3: A sample with `bitIn`=1 counts as +1 and one with `bitIn`=0 counts as -1. For a stream repeating every P samples (P dividing the ratio N) with K ones per period, a fully settled result is floor(N^4·(2K−P)/P · 169678 / 2^S). Here S is 52 for N=7680 and 40 for N=960.
- R4: Values above 131071 give 1FFFFh, and values below −131072 give 20000h. An all-ones stream yields 1FFFFh and an all-zeros stream yields 20000h.
- R5: `settled` is low on the first three strobes after a reset or rate change. It rises in the same cycle as the fourth strobe and stays high until the next clear.
- R6: For a periodic stream applied from a reset, the fourth result is already exact to R3.
- R7: If the stream changes in the middle of a conversion, the fifth result after the change is exact for the new stream.
- R8: A change on `rateSel` clears all filter state and the settled count. `settled` is low in the cycle after the change, the next strobe comes no sooner than one full new-rate conversion later, and the fourth strobe at the new rate is exact.
- R9: Cycles with `sampleEn` low are not samples: the filter state holds and the phase count does not advance. The results for a stream applied only on enabled cycles stay exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 1 | 0: ratio 7680, 1: ratio 960 |
| sampleEn | input | 1 | Marks a cycle that carries a modulator sample |
| bitIn | input | 1 | Modulator bit |
| resultCode | output | 18 | Two's complement conversion result |
| resultValid | output | 1 | One-cycle strobe for a new result |
| settled | output | 1 | Filter history fully refreshed |

## Verification
The result and its strobe are registered six cycles after the edge that takes the last sample of a conversion. One cycle moves the last integrator into the comb pipeline, three more finish the combs, one forms the product, and one clips and registers the output. The bench therefore never counts a fixed delay. It samples at the falling edge and waits for the strobe, then checks the code and `settled` on that strobe cycle, along with the cycle gap since the previous strobe. After a rate change, `settled` is checked at the first falling edge past the clearing edge. For a mid-conversion stream change, the change is placed a bounded random time after a strobe, so that it falls inside the following conversion.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

  // Filter order: number of integrators and of comb stages.
  localparam int unsigned ORDER = 4;
  // Pipeline after the closing sample: comb stages, product, output register.
  localparam int unsigned PIPE_DEPTH = ORDER + 2;

  typedef struct packed {
    logic                  clear;     // wipe all filter state
    logic                  intEn;     // integrators take a sample
    logic                  fastMode;  // selects the scaling shift
    logic [PIPE_DEPTH-1:0] pipeEn;    // per-stage enables of the decimated path
  } ctrl_t;

endpackage

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl
  import sinc4_pkg::*;
#(
  parameter int RATIO_SLOW   = 7680,
  parameter int RATIO_FAST   = 960,
  parameter int SETTLE_COUNT = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  rateSel,
  input  logic  sampleEn,
  output ctrl_t ctrl,
  output logic  resultValid,
  output logic  settled
);

  localparam int RATIO_MAX = (RATIO_SLOW > RATIO_FAST) ? RATIO_SLOW : RATIO_FAST;
  localparam int PHASE_W   = $clog2(RATIO_MAX);
  localparam int CNT_W     = $clog2(SETTLE_COUNT + 1);
  localparam logic [PHASE_W-1:0] LAST_SLOW = PHASE_W'(RATIO_SLOW - 1);
  localparam logic [PHASE_W-1:0] LAST_FAST = PHASE_W'(RATIO_FAST - 1);
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(SETTLE_COUNT - 1);

  logic                  rateQ;
  logic                  flush;
  logic [PHASE_W-1:0]    phase;
  logic [PHASE_W-1:0]    phaseLast;
  logic                  lastSample;
  logic [PIPE_DEPTH-1:0] pipeQ;
  logic [CNT_W-1:0]      strobeCnt;

  always_ff @(posedge clk) rateQ <= rateSel;

  assign flush      = rst || (rateSel != rateQ);
  assign phaseLast  = rateQ ? LAST_FAST : LAST_SLOW;
  assign lastSample = (phase == phaseLast);

  always_ff @(posedge clk) begin
    if (flush)         phase <= '0;
    else if (sampleEn) phase <= lastSample ? '0 : phase + PHASE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (flush) pipeQ <= '0;
    else       pipeQ <= {pipeQ[PIPE_DEPTH-2:0], sampleEn && lastSample};
  end

  always_ff @(posedge clk) begin
    if (flush) resultValid <= 1'b0;
    else       resultValid <= pipeQ[PIPE_DEPTH-1];
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      strobeCnt <= '0;
      settled   <= 1'b0;
    end else if (pipeQ[PIPE_DEPTH-1] && !settled) begin
      if (strobeCnt == CNT_LAST) settled <= 1'b1;
      strobeCnt <= strobeCnt + CNT_W'(1);
    end
  end

  assign ctrl.clear    = flush;
  assign ctrl.intEn    = sampleEn && !flush;
  assign ctrl.fastMode = rateQ;
  assign ctrl.pipeEn   = pipeQ;

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);  // R2
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    phase <= phaseLast);  // R2
  AST_SETTLED_STICKY: assert property (@(posedge clk) disable iff (rst)
    settled && !flush |=> settled);  // R5
  AST_SETTLE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(settled) |-> resultValid);  // R5
  AST_RATE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (rateSel != rateQ) |=> (!settled && !resultValid));  // R8

endmodule

// File: rtl/sinc4_datapath.sv
module sinc4_datapath
  import sinc4_pkg::*;
#(
  parameter int ACC_W      = 56,
  parameter int OUT_W      = 18,
  parameter int SCALE_MUL  = 169678,
  parameter int SHIFT_SLOW = 52,
  parameter int SHIFT_FAST = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             bitIn,
  output logic [OUT_W-1:0] resultCode
);

  localparam int MUL_W  = $clog2(SCALE_MUL + 1) + 1;
  localparam int PROD_W = ACC_W + MUL_W;
  localparam logic signed [ACC_W-1:0]  PLUS_ONE  = ACC_W'(1);
  localparam logic signed [ACC_W-1:0]  MINUS_ONE = -ACC_W'(1);
  localparam logic signed [MUL_W-1:0]  MUL_CONST = MUL_W'(SCALE_MUL);
  localparam logic signed [PROD_W-1:0] POS_LIM   = PROD_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [PROD_W-1:0] NEG_LIM   = -POS_LIM - PROD_W'(1);

  logic signed [ACC_W-1:0]  stepIn;
  logic signed [PROD_W-1:0] prodQ;
  logic signed [PROD_W-1:0] scaled;
  logic        [OUT_W-1:0]  satCode;

  assign stepIn = bitIn ? PLUS_ONE : MINUS_ONE;

  // Integrators at the sample rate, wrap-around arithmetic.
  for (genvar s = 0; s < ORDER; s++) begin : g_int
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] feed;
    if (s == 0) begin : g_first
      assign feed = stepIn;
    end else begin : g_next
      assign feed = g_int[s-1].acc;
    end
    always_ff @(posedge clk) begin
      if (ctrl.clear)      acc <= '0;
      else if (ctrl.intEn) acc <= acc + feed;
    end
  end

  // Comb stages, one per pipeline cycle after the decimation point.
  for (genvar s = 0; s < ORDER; s++) begin : g_comb
    logic signed [ACC_W-1:0] val;
    logic signed [ACC_W-1:0] dly;
    logic signed [ACC_W-1:0] feed;
    if (s == 0) begin : g_first
      assign feed = g_int[ORDER-1].acc;
    end else begin : g_next
      assign feed = g_comb[s-1].val;
    end
    always_ff @(posedge clk) begin
      if (ctrl.clear) begin
        val <= '0;
        dly <= '0;
      end else if (ctrl.pipeEn[s]) begin
        val <= feed - dly;
        dly <= feed;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear)               prodQ <= '0;
    else if (ctrl.pipeEn[ORDER])  prodQ <= PROD_W'(g_comb[ORDER-1].val) * PROD_W'(MUL_CONST);
  end

  assign scaled = ctrl.fastMode ? (prodQ >>> SHIFT_FAST) : (prodQ >>> SHIFT_SLOW);

  always_comb begin
    if (scaled > POS_LIM)      satCode = POS_LIM[OUT_W-1:0];
    else if (scaled < NEG_LIM) satCode = NEG_LIM[OUT_W-1:0];
    else                       satCode = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear)                   resultCode <= '0;
    else if (ctrl.pipeEn[ORDER + 1])  resultCode <= satCode;
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl.pipeEn[ORDER + 1]) && !$past(ctrl.clear) |-> $stable(resultCode));  // R2
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.intEn && !ctrl.clear |=> $stable(g_int[0].acc));  // R9
  AST_COMB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pipeEn[0] && !ctrl.clear |=> $stable(g_comb[0].dly));  // R9

endmodule

// File: rtl/sinc4_rate_decimator.sv
module sinc4_rate_decimator
  import sinc4_pkg::*;
#(
  parameter int RATIO_SLOW   = 7680,
  parameter int RATIO_FAST   = 960,
  parameter int ACC_W        = 56,
  parameter int OUT_W        = 18,
  parameter int SCALE_MUL    = 169678,
  parameter int SHIFT_SLOW   = 52,
  parameter int SHIFT_FAST   = 40,
  parameter int SETTLE_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rateSel,
  input  logic             sampleEn,
  input  logic             bitIn,
  output logic [OUT_W-1:0] resultCode,
  output logic             resultValid,
  output logic             settled
);

  ctrl_t ctrl;

  sinc4_ctrl #(
    .RATIO_SLOW  (RATIO_SLOW),
    .RATIO_FAST  (RATIO_FAST),
    .SETTLE_COUNT(SETTLE_COUNT)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rateSel    (rateSel),
    .sampleEn   (sampleEn),
    .ctrl       (ctrl),
    .resultValid(resultValid),
    .settled    (settled)
  );

  sinc4_datapath #(
    .ACC_W     (ACC_W),
    .OUT_W     (OUT_W),
    .SCALE_MUL (SCALE_MUL),
    .SHIFT_SLOW(SHIFT_SLOW),
    .SHIFT_FAST(SHIFT_FAST)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .bitIn     (bitIn),
    .resultCode(resultCode)
  );

endmodule

// File: tb/sinc4_rate_decimator_tb.sv
module sinc4_rate_decimator_tb;

  localparam int RATIO_SLOW = 7680;
  localparam int RATIO_FAST = 960;
  localparam int CYCLE_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst;
  logic        rateSel;
  logic        sampleEn;
  logic        bitIn;
  logic [17:0] resultCode;
  logic        resultValid;
  logic        settled;

  always #10 clk = ~clk;

  sinc4_rate_decimator u_dut (
    .clk        (clk),
    .rst        (rst),
    .rateSel    (rateSel),
    .sampleEn   (sampleEn),
    .bitIn      (bitIn),
    .resultCode (resultCode),
    .resultValid(resultValid),
    .settled    (settled)
  );

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          lastStrobeCyc = 0;
  bit          timedOut = 1'b0;
  int          curP = 16;
  int          curK = 8;
  int          patIdx = 0;
  bit          gapOn = 1'b0;
  logic        obsValid;
  logic        obsSettled;
  logic [17:0] obsCode;

  function automatic longint expCode(int ratio, int p, int k);
    logic signed [127:0] r4;
    logic signed [127:0] acc;
    logic signed [127:0] prod;
    logic signed [127:0] v;
    r4   = 128'(ratio);
    r4   = r4 * r4 * r4 * r4;
    acc  = (r4 * 128'(2 * k - p)) / 128'(p);
    prod = acc * 128'sd169678;
    v    = prod >>> ((ratio == RATIO_FAST) ? 40 : 52);
    if (v > 128'sd131071)  return 131071;
    if (v < -128'sd131072) return -131072;
    return longint'(v);
  endfunction

  task automatic checkEq(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkGe(string tag, string what, longint act, longint lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected>=%0d", tag, what, act, lim);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > CYCLE_LIMIT) timedOut = 1'b1;
    obsValid   = resultValid;
    obsSettled = settled;
    obsCode    = resultCode;
    sampleEn   = gapOn ? ($urandom_range(3) != 0) : 1'b1;
    if (sampleEn) begin
      bitIn = ((patIdx % curP) < curK);
      patIdx++;
    end
  endtask

  task automatic waitStrobe(output int gap);
    tick();
    while (!obsValid && !timedOut) tick();
    gap = cyc - lastStrobeCyc;
    lastStrobeCyc = cyc;
  endtask

  task automatic setPattern(int p, int k);
    curP = p;
    curK = k;
    patIdx = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    lastStrobeCyc = cyc;
  endtask

  int  gap;
  longint expV;

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; rateSel = 1'b1; sampleEn = 1'b0; bitIn = 1'b0;

    // R1: reset state
    doReset();
    tick();
    checkEq("R1", "valid after reset", obsValid, 0);
    checkEq("R1", "settled after reset", obsSettled, 0);
    checkEq("R1", "code after reset", obsCode, 0);

    // Slow rate from reset: spacing, settling, exact fourth and fifth results
    rateSel = 1'b0;
    setPattern(32, 24);
    doReset();
    expV = expCode(RATIO_SLOW, 32, 24);
    for (int s = 1; s <= 5 && !timedOut; s++) begin
      waitStrobe(gap);
      if (s >= 2) checkEq("R2", "slow strobe spacing", gap, RATIO_SLOW);
      checkEq("R5", "settled at slow strobe", obsSettled, (s >= 4));
      if (s == 4) checkEq("R6", "slow fourth result", $signed(obsCode), expV);
      if (s == 5) checkEq("R3", "slow fifth result", $signed(obsCode), expV);
    end

    // R8: switch to fast without reset
    setPattern(32, 8);
    rateSel = 1'b1;
    tick();
    checkEq("R8", "settled after rate change", obsSettled, 0);
    lastStrobeCyc = cyc;
    for (int s = 1; s <= 4 && !timedOut; s++) begin
      waitStrobe(gap);
      if (s == 1) checkGe("R8", "first gap after rate change", gap, RATIO_FAST);
      else        checkEq("R2", "fast strobe spacing", gap, RATIO_FAST);
      checkEq("R5", "settled at fast strobe", obsSettled, (s >= 4));
      if (s == 4) checkEq("R8", "fourth result at new rate", $signed(obsCode), expCode(RATIO_FAST, 32, 8));
    end

    // R4: saturation at both rails
    setPattern(16, 16);
    doReset();
    for (int s = 1; s <= 4 && !timedOut; s++) waitStrobe(gap);
    checkEq("R4", "all ones clips high", obsCode, 18'h1FFFF);
    setPattern(16, 0);
    doReset();
    for (int s = 1; s <= 4 && !timedOut; s++) waitStrobe(gap);
    checkEq("R4", "all zeros clips low", obsCode, 18'h20000);

    // R3 / R9: random densities, some with sample gaps
    for (int it = 0; it < 10 && !timedOut; it++) begin
      int p;
      int k;
      case ($urandom_range(2))
        0:       p = 16;
        1:       p = 32;
        default: p = 64;
      endcase
      k = $urandom_range(p);
      setPattern(p, k);
      gapOn = (it % 3 == 2);
      doReset();
      for (int s = 1; s <= 4 && !timedOut; s++) begin
        waitStrobe(gap);
        if (s >= 2) begin
          if (gapOn) checkGe("R9", "spacing with gaps", gap, RATIO_FAST);
          else       checkEq("R2", "random spacing", gap, RATIO_FAST);
        end
      end
      if (gapOn) checkEq("R9", "result with sample gaps", $signed(obsCode), expCode(RATIO_FAST, p, k));
      else       checkEq("R3", "random density result", $signed(obsCode), expCode(RATIO_FAST, p, k));
      gapOn = 1'b0;
    end

    // R7: stream change inside a conversion
    setPattern(32, 4);
    doReset();
    for (int s = 1; s <= 4 && !timedOut; s++) waitStrobe(gap);
    checkEq("R3", "settled before change", $signed(obsCode), expCode(RATIO_FAST, 32, 4));
    repeat ($urandom_range(500)) tick();
    setPattern(64, 50);
    for (int s = 1; s <= 5 && !timedOut; s++) waitStrobe(gap);
    checkEq("R7", "fifth result after mid change", $signed(obsCode), expCode(RATIO_FAST, 64, 50));

    if (timedOut) begin
      errors++;
      $display("FAIL watchdog cycles actual=%0d expected<=%0d", cyc, CYCLE_LIMIT);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule